// File: doc/BRIEF.md
# Video Processor Control-Port Decoder

This block is the command front end of a tile-based video processor, as the host sees it over a 16-bit bus. Every write to the control port is decoded either as a single-word load of one configuration register or as one half of a two-word address command. The address command gives the 16-bit target address and a 6-bit access code. The code selects the memory space and the direction, and carries flags that request a memory-to-memory copy or a DMA transfer.

The host issues a 32-bit control write as two 16-bit writes in a row, high word first. A single long access can therefore load two registers, or carry both halves of an address command. A latch marks that the first half of a command has been taken, so the next control write is read as the second half and never as a register load. Reads of the control port return the status word from the surrounding logic. A control read or any data-port access drops a half-finished command.

Top module: `ctlport_decoder`

## Requirements
- R1: After reset, every configuration register, the address, the access code and the pending flag are zero.
- R2: When no command is pending, a control write whose bits 15:14 are 2'b10 loads register number bits 12:8 with bits 7:0. All other registers keep their values, bit 13 is ignored, and the pending flag stays clear.
- R3: A register load whose number is outside the bank (24 or more with the default size) changes no register and leaves the pending flag clear.
- R4: When no command is pending, any other control write is a first half. It loads bits 15:14 into code bits 1:0 and bits 13:0 into address bits 13:0, keeps the upper code and address bits, and sets the pending flag.
- R5: A control write while the flag is pending is a second half, whatever its bits 15:14. It loads bits 7:4 into code bits 5:2 and bits 1:0 into address bits 15:14, ignores bits 15:8 and 3:2, clears the flag and writes no register.
- R6: A control read or a data-port access clears the pending flag. The next control write is then decoded as a first half or as a register load.
- R7: During a control read, the read data equals the status input. Otherwise the read data is zero.
- R8: The direction output is code bit 0 (1 = write), the copy request is code bit 4 and the DMA request is code bit 5.
- R9: The space output decodes code bits 3:0 as follows: 0000 or 0001 gives 1 (pattern memory), 1000 or 0011 gives 2 (palette memory), 0100 or 0101 gives 3 (vertical-scroll memory), and any other value gives 0.
- R10: Two register loads on consecutive cycles, as produced by one 32-bit access, both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control-port write strobe |
| ctl_rd | input | 1 | Control-port read strobe |
| data_acc | input | 1 | Data-port access strobe (read or write) |
| wr_data | input | 16 | Host write word |
| status_in | input | 16 | Status word from the rest of the processor |
| rd_data | output | 16 | Control-port read data |
| reg_flat | output | NUM_REGS*8 | Register bank, register k in bits 8k+7:8k |
| acc_addr | output | 16 | Current target address |
| acc_code | output | 6 | Current access code |
| wr_dir | output | 1 | Direction, 1 = write |
| copy_req | output | 1 | Memory-to-memory copy request |
| dma_req | output | 1 | DMA request |
| tgt_space | output | 2 | Decoded memory space |
| half_pending | output | 1 | First half of an address command taken |

## Verification
The bench builds the block with its default 24-register bank and the combinational status path. With these values the register-number sweep over all 32 encodings reaches both the in-range registers and the eight ignored numbers. The address sweep covers all 48 access codes whose low bits can start a command, so every space decode, the copy and DMA flags, and second-half words with 2'b10 in their top bits are all exercised.

// File: rtl/ctlport_pkg.sv
package ctlport_pkg;
   localparam int unsigned WORD_W = 16;
   localparam int unsigned ADDR_W = 16;
   localparam int unsigned CODE_W = 6;
   localparam int unsigned REG_W  = 8;
   localparam int unsigned IDX_W  = 5;

   typedef enum logic [1:0] {
      SPC_NONE    = 2'd0,
      SPC_PATTERN = 2'd1,
      SPC_PALETTE = 2'd2,
      SPC_VSCROLL = 2'd3
   } space_e;
endpackage

// File: rtl/ctlport_regbank.sv
module ctlport_regbank
   import ctlport_pkg::*;
#(
   parameter int unsigned NUM_REGS = 24
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we,
   input  logic [IDX_W-1:0]          idx,
   input  logic [REG_W-1:0]          wdata,
   output logic [NUM_REGS*REG_W-1:0] flat
);
   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      logic [REG_W-1:0] r_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            r_q <= '0;
         else if (we && (idx == IDX_W'(i)))
            r_q <= wdata;
      end
      assign flat[i*REG_W +: REG_W] = r_q;
   end
endmodule

// File: rtl/ctlport_cmdlatch.sv
module ctlport_cmdlatch
   import ctlport_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic              ctl_rd,
   input  logic              data_acc,
   input  logic [WORD_W-1:0] wr_data,
   output logic              reg_we,
   output logic [IDX_W-1:0]  reg_idx,
   output logic [REG_W-1:0]  reg_data,
   output logic [ADDR_W-1:0] addr,
   output logic [CODE_W-1:0] code,
   output logic              pending
);
   logic              pend_q;
   logic [ADDR_W-1:0] addr_q;
   logic [CODE_W-1:0] code_q;
   logic              is_reg, first_half, second_half;

   always_comb begin
      is_reg      = (wr_data[15:14] == 2'b10);
      reg_we      = ctl_wr && !pend_q && is_reg;
      first_half  = ctl_wr && !pend_q && !is_reg;
      second_half = ctl_wr && pend_q;
      reg_idx     = wr_data[12:8];
      reg_data    = wr_data[7:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         addr_q <= '0;
         code_q <= '0;
      end else begin
         if (first_half) begin
            code_q[1:0]  <= wr_data[15:14];
            addr_q[13:0] <= wr_data[13:0];
         end
         if (second_half) begin
            code_q[5:2]   <= wr_data[7:4];
            addr_q[15:14] <= wr_data[1:0];
         end
         if (ctl_rd || data_acc)
            pend_q <= 1'b0;
         else if (first_half)
            pend_q <= 1'b1;
         else if (second_half)
            pend_q <= 1'b0;
      end
   end

   assign addr    = addr_q;
   assign code    = code_q;
   assign pending = pend_q;
endmodule

// File: rtl/ctlport_space_dec.sv
module ctlport_space_dec
   import ctlport_pkg::*;
(
   input  logic [CODE_W-1:0] code,
   output space_e            space,
   output logic              is_write,
   output logic              copy,
   output logic              dma
);
   always_comb begin
      unique case (code[3:0])
         4'b0000, 4'b0001: space = SPC_PATTERN;
         4'b1000, 4'b0011: space = SPC_PALETTE;
         4'b0100, 4'b0101: space = SPC_VSCROLL;
         default:          space = SPC_NONE;
      endcase
      is_write = code[0];
      copy     = code[4];
      dma      = code[5];
   end
endmodule

// File: rtl/ctlport_decoder.sv
module ctlport_decoder
   import ctlport_pkg::*;
#(
   parameter int unsigned NUM_REGS   = 24,
   parameter int unsigned STATUS_REG = 0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      ctl_wr,
   input  logic                      ctl_rd,
   input  logic                      data_acc,
   input  logic [WORD_W-1:0]         wr_data,
   input  logic [WORD_W-1:0]         status_in,
   output logic [WORD_W-1:0]         rd_data,
   output logic [NUM_REGS*REG_W-1:0] reg_flat,
   output logic [ADDR_W-1:0]         acc_addr,
   output logic [CODE_W-1:0]         acc_code,
   output logic                      wr_dir,
   output logic                      copy_req,
   output logic                      dma_req,
   output logic [1:0]                tgt_space,
   output logic                      half_pending
);
   localparam int unsigned IDX_SPAN = 1 << IDX_W;

   if (NUM_REGS < 1 || NUM_REGS > IDX_SPAN) begin : g_bad_size
      $error("ctlport_decoder: NUM_REGS out of range");
   end
   if (STATUS_REG > 1) begin : g_bad_status
      $error("ctlport_decoder: STATUS_REG must be 0 or 1");
   end

   logic             reg_we;
   logic [IDX_W-1:0] reg_idx;
   logic [REG_W-1:0] reg_data;
   space_e           space;

   ctlport_cmdlatch u_cmd (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_wr   (ctl_wr),
      .ctl_rd   (ctl_rd),
      .data_acc (data_acc),
      .wr_data  (wr_data),
      .reg_we   (reg_we),
      .reg_idx  (reg_idx),
      .reg_data (reg_data),
      .addr     (acc_addr),
      .code     (acc_code),
      .pending  (half_pending)
   );

   ctlport_regbank #(.NUM_REGS(NUM_REGS)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (reg_we),
      .idx   (reg_idx),
      .wdata (reg_data),
      .flat  (reg_flat)
   );

   ctlport_space_dec u_dec (
      .code     (acc_code),
      .space    (space),
      .is_write (wr_dir),
      .copy     (copy_req),
      .dma      (dma_req)
   );
   assign tgt_space = space;

   if (STATUS_REG == 0) begin : g_stat_comb
      assign rd_data = ctl_rd ? status_in : '0;
   end else begin : g_stat_reg
      logic [WORD_W-1:0] rd_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            rd_q <= '0;
         else
            rd_q <= ctl_rd ? status_in : '0;
      end
      assign rd_data = rd_q;
   end
endmodule

// File: rtl/ctlport_checker.sv
module ctlport_checker
   import ctlport_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              ctl_wr,
   input logic              ctl_rd,
   input logic              data_acc,
   input logic [WORD_W-1:0] wr_data,
   input logic [ADDR_W-1:0] acc_addr,
   input logic [CODE_W-1:0] acc_code,
   input logic              half_pending
);
   a_r4_first_half_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && !half_pending && wr_data[15:14] != 2'b10 && !ctl_rd && !data_acc)
      |=> half_pending);

   a_r4_first_half_fields: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && !half_pending && wr_data[15:14] != 2'b10)
      |=> (acc_addr[13:0] == $past(wr_data[13:0])) && (acc_code[1:0] == $past(wr_data[15:14])));

   a_r2_regload_keeps_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && !half_pending && wr_data[15:14] == 2'b10) |=> !half_pending);

   a_r5_second_half_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && half_pending) |=> !half_pending);

   a_r5_second_half_fields: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && half_pending)
      |=> (acc_addr[15:14] == $past(wr_data[1:0])) && (acc_code[5:2] == $past(wr_data[7:4])));

   a_r6_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_rd || data_acc) |=> !half_pending);

   a_r6_no_write_holds_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_wr |=> ($stable(acc_addr) && $stable(acc_code)));
endmodule

bind ctlport_decoder ctlport_checker u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ctl_wr       (ctl_wr),
   .ctl_rd       (ctl_rd),
   .data_acc     (data_acc),
   .wr_data      (wr_data),
   .acc_addr     (acc_addr),
   .acc_code     (acc_code),
   .half_pending (half_pending)
);

// File: tb/ctlport_decoder_test.sv
module ctlport_decoder_test;
   localparam int CLK_PERIOD = 10;
   localparam int NREG = 24;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ctl_wr = 1'b0, ctl_rd = 1'b0, data_acc = 1'b0;
   logic [15:0] wr_data = '0, status_in = '0, rd_data;
   logic [NREG*8-1:0] reg_flat;
   logic [15:0] acc_addr;
   logic [5:0]  acc_code;
   logic wr_dir, copy_req, dma_req, half_pending;
   logic [1:0] tgt_space;

   int n_run = 0, n_fail = 0;
   bit done = 0;

   logic [NREG*8-1:0] e_regs;
   logic [15:0] e_addr;
   logic [5:0]  e_code;
   logic        e_pend;

   always #(CLK_PERIOD/2) clk = ~clk;

   ctlport_decoder uut (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_rd(ctl_rd), .data_acc(data_acc),
      .wr_data(wr_data), .status_in(status_in), .rd_data(rd_data), .reg_flat(reg_flat),
      .acc_addr(acc_addr), .acc_code(acc_code), .wr_dir(wr_dir), .copy_req(copy_req),
      .dma_req(dma_req), .tgt_space(tgt_space), .half_pending(half_pending)
   );

   task automatic chk(input bit ok, input string req, input logic [191:0] act, input logic [191:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Spec model of one control write (R2..R5)
   task automatic model_write(input logic [15:0] w);
      if (!e_pend) begin
         if (w[15:14] == 2'b10) begin
            if (int'(w[12:8]) < NREG) e_regs[int'(w[12:8])*8 +: 8] = w[7:0];
         end else begin
            e_code[1:0] = w[15:14];
            e_addr[13:0] = w[13:0];
            e_pend = 1'b1;
         end
      end else begin
         e_code[5:2] = w[7:4];
         e_addr[15:14] = w[1:0];
         e_pend = 1'b0;
      end
   endtask

   task automatic ctl_write(input logic [15:0] w);
      @(negedge clk);
      ctl_wr = 1'b1; wr_data = w;
      @(negedge clk);
      ctl_wr = 1'b0;
      model_write(w);
   endtask

   task automatic check_state(input string req);
      chk(reg_flat == e_regs, req, reg_flat, e_regs);
      chk(acc_addr == e_addr, req, acc_addr, e_addr);
      chk(acc_code == e_code, req, acc_code, e_code);
      chk(half_pending == e_pend, req, half_pending, e_pend);
   endtask

   function automatic logic [1:0] exp_space(input logic [3:0] c);
      case (c)
         4'b0000, 4'b0001: return 2'd1;
         4'b1000, 4'b0011: return 2'd2;
         4'b0100, 4'b0101: return 2'd3;
         default:          return 2'd0;
      endcase
   endfunction

   initial begin
      #(CLK_PERIOD*200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      e_regs = '0; e_addr = '0; e_code = '0; e_pend = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_state("R1 reset");

      // R2/R3: sweep all 32 register numbers, bit 13 toggled
      for (int i = 0; i < 32; i++) begin
         logic [15:0] w;
         w = {2'b10, i[0], i[4:0], 8'((i * 37 + 5) & 8'hFF)};
         ctl_write(w);
         check_state(i < NREG ? "R2 register load" : "R3 out-of-range ignored");
      end

      // R10: two loads on consecutive cycles
      @(negedge clk);
      ctl_wr = 1'b1; wr_data = 16'h8311;
      @(negedge clk);
      wr_data = 16'h9722;
      @(negedge clk);
      ctl_wr = 1'b0;
      model_write(16'h8311); model_write(16'h9722);
      check_state("R10 back-to-back loads");

      // R4/R5/R8/R9: sweep access codes
      for (int c = 0; c < 64; c++) begin
         logic [15:0] a, w1, w2;
         logic [5:0] cc;
         cc = 6'(c);
         if (cc[1:0] == 2'b10) continue;
         a = 16'((c * 16'h0A3B + 16'h1234) & 16'hFFFF);
         w1 = {cc[1:0], a[13:0]};
         w2 = {8'h9F, cc[5:2], 2'b11, a[15:14]};
         ctl_write(w1);
         check_state("R4 first half");
         ctl_write(w2);
         check_state("R5 second half");
         chk(tgt_space == exp_space(cc[3:0]), "R9 space decode", tgt_space, exp_space(cc[3:0]));
         chk({dma_req, copy_req, wr_dir} == {cc[5], cc[4], cc[0]}, "R8 flags",
             {dma_req, copy_req, wr_dir}, {cc[5], cc[4], cc[0]});
      end

      // R6: control read aborts a pending command
      ctl_write(16'h4123);
      check_state("R6 pending set");
      @(negedge clk); ctl_rd = 1'b1;
      @(negedge clk); ctl_rd = 1'b0; e_pend = 1'b0;
      check_state("R6 read clears pending");
      ctl_write(16'h8455);
      check_state("R6 load after read abort");

      // R6: data access aborts a pending command
      ctl_write(16'h0077);
      @(negedge clk); data_acc = 1'b1;
      @(negedge clk); data_acc = 1'b0; e_pend = 1'b0;
      check_state("R6 data access clears pending");
      ctl_write(16'hC001);
      check_state("R6 first half after data abort");
      ctl_write(16'h0030);
      check_state("R6 completes");

      // R7: status read path
      @(negedge clk);
      status_in = 16'hBEEF;
      #1 chk(rd_data == 16'h0000, "R7 idle read data", rd_data, 16'h0);
      ctl_rd = 1'b1;
      #1 chk(rd_data == 16'hBEEF, "R7 status returned", rd_data, 16'hBEEF);
      status_in = 16'h3A5C;
      #1 chk(rd_data == 16'h3A5C, "R7 status follows", rd_data, 16'h3A5C);
      @(negedge clk); ctl_rd = 1'b0;
      #1 chk(rd_data == 16'h0000, "R7 read ends", rd_data, 16'h0);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule